// File: doc/BRIEF.md
# Time-Triggered Reference Timer

This block keeps the running time base of a time-triggered message controller. A 16-bit counter advances once for each timer-clock enable. Time-triggered mode can be on. In that mode, the counter returns to zero when a reference message has been fully received into the last mailbox. The rising edge of that mailbox's ready flag marks this moment, so each basic cycle starts when its reference message arrives. Software can also clear the counter directly with a strobe.

An optional freeze setting stops the counter at its top value and does not let it wrap. When the counter freezes, a sticky overflow status bit is set. Reading the status register clears that bit, and the bit can drive an interrupt through an enable. The freeze lasts until the counter is restarted.

The block also captures the counter into a global timestamp when a timestamp event occurs. A per-mailbox view of that timestamp reads as zero while time-triggered mode is active.

Top module: `tt_ref_timer`

## Requirements
- R1: After reset, `count`, `frozen`, `ovf_flag`, `ovf_irq`, `stamp` and `mb_stamp` are all zero.
- R2: On each clock edge where `tick_en` is 1, the counter is not frozen and no restart is pending, `count` increases by one. With `tick_en` at 0 it holds.
- R3: With `tt_mode` at 1, a 0-to-1 change of `last_mb_rdy` (compared with the previous clock) clears `count` to 0 and releases a freeze on the next edge. Holding the flag at 1 does not clear again. With `tt_mode` at 0, the edge has no effect.
- R4: A `cnt_clr` strobe clears `count` to 0 and releases a freeze on the next edge. It takes priority over a tick in the same cycle.
- R5: With `freeze_en` at 1, a tick while `count` is 0xFFFF sets `frozen` and leaves `count` at 0xFFFF. Further ticks change nothing until a restart (R3 or R4).
- R6: With `freeze_en` at 0, a tick at 0xFFFF wraps `count` to 0x0000 and does not set `ovf_flag`.
- R7: `ovf_flag` is set on the edge where the counter freezes. It is cleared on an edge where `stat_rd` is 1. If both occur on the same edge, it stays set.
- R8: `ovf_irq` is 1 exactly when `ovf_flag` and `ovf_ie` are both 1.
- R9: A `stamp_evt` pulse loads the value `count` had in that cycle into `stamp` on the next edge. `mb_stamp` equals `stamp` when `tt_mode` is 0 and reads 0 when `tt_mode` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer-clock enable, one count per high cycle |
| tt_mode | input | 1 | Time-triggered mode enable |
| freeze_en | input | 1 | Saturate at top value instead of wrapping |
| last_mb_rdy | input | 1 | Message-ready flag of the last mailbox |
| cnt_clr | input | 1 | Software counter clear strobe |
| stat_rd | input | 1 | Status register read strobe |
| ovf_ie | input | 1 | Overflow interrupt enable |
| stamp_evt | input | 1 | Timestamp capture event |
| count | output | 16 | Current counter value |
| frozen | output | 1 | Counter is frozen at top value |
| ovf_flag | output | 1 | Sticky overflow status |
| ovf_irq | output | 1 | Overflow interrupt request |
| stamp | output | 16 | Global captured timestamp |
| mb_stamp | output | 16 | Per-mailbox timestamp view |

## Verification
A wrong internal state shows up on `count` within one clock, because every increment, restart and freeze is visible on the next edge. A missed or repeated reference edge leaves the counter off from the expected value from that point on, and the error never corrects itself. A freeze that is missed or released early shows as `count` leaving 0xFFFF, and an overflow flag that is wrong shows on `ovf_flag` and `ovf_irq` in the same cycle. The bench therefore compares all outputs against a behavioural model on every clock, so the first wrong edge is reported.

// File: rtl/tt_timer_pkg.sv
package tt_timer_pkg;

  typedef enum logic [2:0] {
    STEP_HOLD   = 3'd0,
    STEP_INC    = 3'd1,
    STEP_WRAP   = 3'd2,
    STEP_FREEZE = 3'd3,
    STEP_CLEAR  = 3'd4
  } step_e;

  // Decide how the counter moves on this edge; restart wins over everything.
  function automatic step_e pick_step(input logic restart, input logic tick,
                                      input logic is_frozen, input logic at_top,
                                      input logic sat_en);
    step_e s;
    if (restart)                s = STEP_CLEAR;
    else if (!tick || is_frozen) s = STEP_HOLD;
    else if (!at_top)           s = STEP_INC;
    else if (sat_en)            s = STEP_FREEZE;
    else                        s = STEP_WRAP;
    return s;
  endfunction

  // Rising edge between the previous and present sample of a level flag.
  function automatic logic rise_of(input logic prev, input logic now);
    return now & ~prev;
  endfunction

  // Sticky flag update: a set outranks a clear in the same cycle.
  function automatic logic sticky_next(input logic cur, input logic set,
                                       input logic clr);
    logic n;
    if (set)      n = 1'b1;
    else if (clr) n = 1'b0;
    else          n = cur;
    return n;
  endfunction

endpackage

// File: rtl/tt_ref_edge.sv
module tt_ref_edge
  import tt_timer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_lvl,
  input  logic mode_on,
  input  logic sw_clr,
  output logic ref_evt,
  output logic restart
);
  logic rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= rdy_lvl;
  end

  assign ref_evt = mode_on & rise_of(rdy_q, rdy_lvl);
  assign restart = ref_evt | sw_clr;
endmodule

// File: rtl/tt_count_core.sv
module tt_count_core
  import tt_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic             sat_en,
  output logic [CNT_W-1:0] value,
  output logic             is_frozen,
  output logic             freeze_evt,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  step_e step;
  assign step       = pick_step(restart, tick, is_frozen, value == TOP, sat_en);
  assign freeze_evt = (step == STEP_FREEZE);
  assign wrap_evt   = (step == STEP_WRAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value     <= '0;
      is_frozen <= 1'b0;
    end else begin
      case (step)
        STEP_CLEAR: begin
          value     <= '0;
          is_frozen <= 1'b0;
        end
        STEP_INC:    value     <= value + 1'b1;
        STEP_WRAP:   value     <= '0;
        STEP_FREEZE: is_frozen <= 1'b1;
        default:     value     <= value;
      endcase
    end
  end
endmodule

// File: rtl/tt_ovf_status.sv
module tt_ovf_status
  import tt_timer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic rd_clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= sticky_next(flag, set_evt, rd_clr);
  end

  assign irq = flag & irq_en;
endmodule

// File: rtl/tt_stamp_reg.sv
module tt_stamp_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grab,
  input  logic             mode_on,
  input  logic [CNT_W-1:0] src,
  output logic [CNT_W-1:0] global_q,
  output logic [CNT_W-1:0] mbox_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    global_q <= '0;
    else if (grab) global_q <= src;
  end

  assign mbox_q = mode_on ? '0 : global_q;
endmodule

// File: rtl/tt_ref_timer.sv
module tt_ref_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             tt_mode,
  input  logic             freeze_en,
  input  logic             last_mb_rdy,
  input  logic             cnt_clr,
  input  logic             stat_rd,
  input  logic             ovf_ie,
  input  logic             stamp_evt,
  output logic [CNT_W-1:0] count,
  output logic             frozen,
  output logic             ovf_flag,
  output logic             ovf_irq,
  output logic [CNT_W-1:0] stamp,
  output logic [CNT_W-1:0] mb_stamp
);
  logic ref_evt;
  logic restart;
  logic freeze_evt;
  logic wrap_evt;

  tt_ref_edge u_edge (
    .clk(clk), .rst_n(rst_n), .rdy_lvl(last_mb_rdy), .mode_on(tt_mode),
    .sw_clr(cnt_clr), .ref_evt(ref_evt), .restart(restart)
  );

  tt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .restart(restart),
    .sat_en(freeze_en), .value(count), .is_frozen(frozen),
    .freeze_evt(freeze_evt), .wrap_evt(wrap_evt)
  );

  tt_ovf_status u_ovf (
    .clk(clk), .rst_n(rst_n), .set_evt(freeze_evt), .rd_clr(stat_rd),
    .irq_en(ovf_ie), .flag(ovf_flag), .irq(ovf_irq)
  );

  tt_stamp_reg #(.CNT_W(CNT_W)) u_stamp (
    .clk(clk), .rst_n(rst_n), .grab(stamp_evt), .mode_on(tt_mode),
    .src(count), .global_q(stamp), .mbox_q(mb_stamp)
  );
endmodule

// File: rtl/tt_ref_timer_chk.sv
module tt_ref_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             tt_mode,
  input logic             freeze_en,
  input logic             stat_rd,
  input logic             ovf_ie,
  input logic             stamp_evt,
  input logic [CNT_W-1:0] count,
  input logic             frozen,
  input logic             ovf_flag,
  input logic             ovf_irq,
  input logic [CNT_W-1:0] stamp,
  input logic [CNT_W-1:0] mb_stamp,
  input logic             restart,
  input logic             freeze_evt,
  input logic             wrap_evt
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !restart && !frozen && count != TOP) |=> count == $past(count) + 1'b1);
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !restart) |=> $stable(count));
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == '0 && !frozen));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !restart) |=> (frozen && $stable(count)));
  a_r5_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> count == TOP);
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> count == '0);
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze_en && !ovf_flag) |=> !ovf_flag);
  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_evt |=> ovf_flag);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !freeze_evt) |=> !ovf_flag);
  a_r8_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> (ovf_flag && ovf_ie));
  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_evt |=> stamp == $past(count));
  a_r9_mbox_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tt_mode |-> mb_stamp == '0);
endmodule

bind tt_ref_timer tt_ref_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tt_mode(tt_mode),
  .freeze_en(freeze_en), .stat_rd(stat_rd), .ovf_ie(ovf_ie),
  .stamp_evt(stamp_evt), .count(count), .frozen(frozen),
  .ovf_flag(ovf_flag), .ovf_irq(ovf_irq), .stamp(stamp),
  .mb_stamp(mb_stamp), .restart(restart), .freeze_evt(freeze_evt),
  .wrap_evt(wrap_evt)
);

// File: tb/test_tt_ref_timer.sv
module test_tt_ref_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 180000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 0, tt_mode = 0, freeze_en = 0, last_mb_rdy = 0;
  logic cnt_clr = 0, stat_rd = 0, ovf_ie = 0, stamp_evt = 0;
  logic [15:0] count, stamp, mb_stamp;
  logic frozen, ovf_flag, ovf_irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  int  m_cnt = 0, m_stamp = 0;
  bit  m_frz = 0, m_ovf = 0, m_rdy_q = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tt_ref_timer i_tt_ref_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tt_mode(tt_mode),
    .freeze_en(freeze_en), .last_mb_rdy(last_mb_rdy), .cnt_clr(cnt_clr),
    .stat_rd(stat_rd), .ovf_ie(ovf_ie), .stamp_evt(stamp_evt),
    .count(count), .frozen(frozen), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq),
    .stamp(stamp), .mb_stamp(mb_stamp)
  );

  always @(posedge clk) begin
    bit edge_seen, clr, set_o;
    if (!rst_n) begin
      m_cnt = 0; m_stamp = 0; m_frz = 0; m_ovf = 0; m_rdy_q = 0;
    end else begin
      edge_seen = last_mb_rdy && !m_rdy_q;
      m_rdy_q   = last_mb_rdy;
      clr       = cnt_clr || (tt_mode && edge_seen);
      set_o     = 0;
      if (stamp_evt) m_stamp = m_cnt;
      if (clr) begin
        m_cnt = 0; m_frz = 0;
      end else if (tick_en && !m_frz) begin
        if (m_cnt == 65535) begin
          if (freeze_en) begin m_frz = 1; set_o = 1; end
          else m_cnt = 0;
        end else m_cnt = m_cnt + 1;
      end
      if (set_o) m_ovf = 1;
      else if (stat_rd) m_ovf = 0;
    end
  end

  task automatic chk(input int act, input int exp, input string req, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(count, m_cnt, "R2", "count vs model");
      chk(frozen, m_frz, "R5", "frozen vs model");
      chk(ovf_flag, m_ovf, "R7", "ovf_flag vs model");
      chk(ovf_irq, m_ovf && ovf_ie, "R8", "ovf_irq vs model");
      chk(stamp, m_stamp, "R9", "stamp vs model");
      chk(mb_stamp, tt_mode ? 0 : m_stamp, "R9", "mb_stamp vs model");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    chk(count, 0, "R1", "count in reset");
    rst_n = 1'b1;
    cyc(1);
    chk(count, 0, "R1", "count after reset");
    chk(ovf_flag, 0, "R1", "ovf after reset");
    chk(stamp, 0, "R1", "stamp after reset");
    chk(frozen, 0, "R1", "frozen after reset");

    // R2: steady and gapped ticking
    tick_en = 1; cyc(10);
    chk(count, 10, "R2", "ten ticks");
    for (int i = 0; i < 8; i++) begin tick_en = i[0]; cyc(1); end
    tick_en = 0; cyc(2);
    chk(count, 14, "R2", "gapped ticks");

    // R9: capture and per-mailbox view
    stamp_evt = 1; cyc(1); stamp_evt = 0;
    chk(stamp, 14, "R9", "captured value");
    chk(mb_stamp, 14, "R9", "mailbox view outside tt mode");
    tt_mode = 1; cyc(1);
    chk(mb_stamp, 0, "R9", "mailbox view in tt mode");

    // R3: reference edge in tt mode, held level, edge outside tt mode
    tick_en = 1; cyc(5);
    last_mb_rdy = 1; cyc(1);
    chk(count, 0, "R3", "ref edge clears");
    cyc(4);
    chk(count, 4, "R3", "held flag no re-clear");
    last_mb_rdy = 0; cyc(2);
    tt_mode = 0; last_mb_rdy = 1; cyc(1);
    chk(count, 7, "R3", "edge ignored outside tt mode");
    last_mb_rdy = 0;

    // R4: software clear beats tick
    cyc(3);
    cnt_clr = 1; cyc(1); cnt_clr = 0;
    chk(count, 0, "R4", "software clear");

    // R6: wrap without freeze
    freeze_en = 0;
    cyc(65535);
    chk(count, 65535, "R6", "at top");
    cyc(1);
    chk(count, 0, "R6", "wrapped");
    chk(ovf_flag, 0, "R6", "no overflow on wrap");

    // R5/R7: freeze with a status read in the same cycle
    freeze_en = 1; ovf_ie = 1;
    cnt_clr = 1; cyc(1); cnt_clr = 0;
    cyc(65535);
    chk(count, 65535, "R5", "at top before freeze");
    stat_rd = 1; cyc(1); stat_rd = 0;
    chk(frozen, 1, "R5", "frozen");
    chk(ovf_flag, 1, "R7", "set wins over read");
    chk(ovf_irq, 1, "R8", "irq with enable");
    cyc(20);
    chk(count, 65535, "R5", "held while frozen");
    ovf_ie = 0; cyc(1);
    chk(ovf_irq, 0, "R8", "irq masked");
    stat_rd = 1; cyc(1); stat_rd = 0;
    chk(ovf_flag, 0, "R7", "cleared by read");
    chk(frozen, 1, "R5", "still frozen after read");

    // R3: reference edge releases freeze
    tt_mode = 1; last_mb_rdy = 1; cyc(1); last_mb_rdy = 0;
    chk(frozen, 0, "R3", "freeze released");
    chk(count, 0, "R3", "count restarted");
    cyc(3);
    chk(count, 3, "R2", "counting again");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule